// File: doc/BRIEF.md
# Sectored Data Cache Fill Controller

This block is the lookup and refill engine of a two-way set-associative data cache. Each tag entry covers a sector of two 32-byte lines, and each line has its own valid and modified bits. A CPU request is first looked up against both ways of its set. The result is one of three outcomes: a hit on a valid line, a line fill when the tag matches but the wanted line is absent, or a sector replacement when no way holds the tag.

Replacement follows allocation order. One pointer bit per set names the way that receives the next new sector, and only a sector replacement moves it. Before a sector is reused, any modified lines in it are written back to memory. Line fills arrive over a burst memory port as four 64-bit beats.

With write allocation on, a write that misses is turned into a fill, and the write bytes are merged into the line after it arrives. With write allocation off, the write goes to memory as one single-beat write and nothing is allocated.

Top module: `sector_fill_ctrl`

## Requirements
- R1: A read whose sector tag matches a way and whose line is valid returns the 64-bit word selected by address bits [4:3]. It causes no memory traffic. The address layout is: bits [4:3] select the word, bit 5 selects the line in the sector, the next log2(SETS) bits select the set, and the remaining upper bits are the tag.
- R2: When no way of the set holds the tag, exactly one burst read fetches the requested line into the victim way. The other line of that sector becomes invalid, so a later access to it fetches it from memory.
- R3: When the tag matches but the requested line is invalid, only that line is fetched. The other line of the sector keeps its state and keeps hitting.
- R4: Each set has a pointer bit, cleared at reset, that names the victim way. Each sector replacement in the set inverts it. Hits and line fills leave it unchanged.
- R5: A fill raises mem_req with mem_we=0, mem_burst=1 and a 32-byte-aligned address until mem_ack. It then takes four beats, each marked by mem_rvalid, with possible idle cycles between beats. The line is valid only after the fourth beat.
- R6: With wa_en=1, a write miss performs a fill and issues no single write. The bytes whose cpu_be bit is set are merged into the filled line. cpu_done rises in the second cycle after the cycle in which the final beat is presented.
- R7: With wa_en=0, a write miss issues one memory write with mem_burst=0, the request address, cpu_be and cpu_wdata. It allocates nothing, so a later read of that address performs a fill.
- R8: A write hit updates only the bytes enabled by cpu_be, marks the line modified, and causes no memory traffic.
- R9: Before a sector replacement reuses a way, each valid modified line of that way is written back as four writes with mem_burst=1, all byte enables set and word-aligned addresses. A later read returns the written data.
- R10: cpu_ready is high only when the block is idle. It falls on the cycle after a request is accepted and stays low until completion. mem_req is never high while cpu_ready is high. cpu_done is a one-cycle pulse.
- R11: After reset, cpu_ready is high, mem_req and cpu_done are low, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wa_en | input | 1 | Write allocation enable |
| cpu_req | input | 1 | Request strobe, taken when cpu_ready is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_be | input | 8 | Byte enables of the write word |
| cpu_wdata | input | 64 | Write data |
| cpu_ready | output | 1 | Idle, a request can be accepted |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 64 | Read data, valid with cpu_done on reads |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = write beat, 0 = burst read |
| mem_burst | output | 1 | 1 = part of a line transfer, 0 = single write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| mem_be | output | 8 | Memory byte enables |
| mem_ack | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 64 | Read beat data |

## Verification
The bench builds the block with SETS=4 and ADDR_W=32, so an address span of a few kilobytes gives six tags competing for each of four sets. Replacement, allocation order, sibling invalidation and dirty write-back therefore occur within a few accesses. It also makes a full read sweep of every word of all six tags practical. A responder that throttles acknowledgements and leaves gaps between read beats exercises the handshake. A flat memory image computed arithmetically serves as the expected result of every read.

// File: rtl/sector_fill_ctrl.sv
module sector_fill_ctrl #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wa_en,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_be,
  input  logic [63:0]       cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [63:0]       cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_burst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  output logic [7:0]        mem_be,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata
);
  localparam int SW = $clog2(SETS);
  localparam int TW = ADDR_W - 6 - SW;

  typedef enum logic [2:0] {IDLE, LOOK, WBK, FREQ, FDAT, WSGL} st_t;
  st_t st;

  logic [ADDR_W-1:0] ra;
  logic              rwe;
  logic [7:0]        rbe;
  logic [63:0]       rwd;

  logic [TW-1:0] tag_q [2*SETS];
  logic [1:0]    vld_q [2*SETS];
  logic [1:0]    drt_q [2*SETS];
  logic [63:0]   dat_q [16*SETS];
  logic [SETS-1:0] lra_q;

  logic       fw, sect;
  logic [2:0] cnt;

  logic [SW-1:0] s;
  logic          ln;
  logic [1:0]    wd;
  logic [TW-1:0] tg;
  logic          m0, m1, mw, match, hit, vw, vdirty, wb_need, fill_beat, fill_last;
  logic [63:0]   hword;

  assign s  = ra[6 +: SW];
  assign ln = ra[5];
  assign wd = ra[4:3];
  assign tg = ra[ADDR_W-1 -: TW];

  assign m0      = (|vld_q[{s, 1'b0}]) && (tag_q[{s, 1'b0}] == tg);
  assign m1      = (|vld_q[{s, 1'b1}]) && (tag_q[{s, 1'b1}] == tg);
  assign mw      = m1;
  assign match   = m0 | m1;
  assign hit     = match && vld_q[{s, mw}][ln];
  assign hword   = dat_q[{s, mw, ln, wd}];
  assign vw      = lra_q[s];
  assign vdirty  = |(vld_q[{s, vw}] & drt_q[{s, vw}]);
  assign wb_need = vld_q[{s, fw}][cnt[2]] & drt_q[{s, fw}][cnt[2]];

  assign fill_beat = (st == FDAT) && mem_rvalid;
  assign fill_last = fill_beat && (cnt[1:0] == 2'd3);

  assign cpu_ready = (st == IDLE);
  assign mem_req   = (st == WBK && wb_need) || st == FREQ || st == WSGL;
  assign mem_we    = (st == WBK) || (st == WSGL);
  assign mem_burst = (st != WSGL);
  assign mem_addr  = (st == WBK)  ? {tag_q[{s, fw}], s, cnt, 3'b000} :
                     (st == FREQ) ? {tg, s, ln, 5'b00000} : ra;
  assign mem_wdata = (st == WBK) ? dat_q[{s, fw, cnt}] : rwd;
  assign mem_be    = (st == WBK) ? 8'hFF : rbe;

  function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] n,
                                        input logic [7:0] be);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      ra        <= '0;
      rwe       <= 1'b0;
      rbe       <= '0;
      rwd       <= '0;
      fw        <= 1'b0;
      sect      <= 1'b0;
      cnt       <= '0;
      lra_q     <= '0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      for (int i = 0; i < 2*SETS; i++) begin
        vld_q[i] <= 2'b00;
        drt_q[i] <= 2'b00;
      end
    end else begin
      cpu_done <= 1'b0;
      case (st)
        IDLE: if (cpu_req) begin
          ra  <= cpu_addr;
          rwe <= cpu_we;
          rbe <= cpu_be;
          rwd <= cpu_wdata;
          st  <= LOOK;
        end
        LOOK: begin
          if (hit) begin
            cpu_done <= 1'b1;
            st       <= IDLE;
            if (rwe) drt_q[{s, mw}] <= drt_q[{s, mw}] | (2'b01 << ln);
            else     cpu_rdata <= hword;
          end else if (rwe && !wa_en) begin
            st <= WSGL;
          end else if (match) begin
            fw   <= mw;
            sect <= 1'b0;
            cnt  <= '0;
            st   <= FREQ;
          end else begin
            fw   <= vw;
            sect <= 1'b1;
            cnt  <= '0;
            st   <= vdirty ? WBK : FREQ;
          end
        end
        WBK: if (!wb_need || mem_ack) begin
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7) st <= FREQ;
        end
        FREQ: if (mem_ack) begin
          cnt <= '0;
          st  <= FDAT;
        end
        FDAT: if (mem_rvalid) begin
          cnt <= cnt + 3'd1;
          if (cnt[1:0] == 2'd3) begin
            vld_q[{s, fw}] <= (sect ? 2'b00 : vld_q[{s, fw}]) | (2'b01 << ln);
            drt_q[{s, fw}] <= (sect ? 2'b00 : drt_q[{s, fw}]) & ~(2'b01 << ln);
            if (sect) lra_q[s] <= ~lra_q[s];
            st <= LOOK;
          end
        end
        WSGL: if (mem_ack) begin
          cpu_done <= 1'b1;
          st       <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fill_beat)
      dat_q[{s, fw, ln, cnt[1:0]}] <= mem_rdata;
    else if (st == LOOK && hit && rwe)
      dat_q[{s, mw, ln, wd}] <= merge(hword, rwd, rbe);
    if (fill_last && sect)
      tag_q[{s, fw}] <= tg;
  end
endmodule

// File: rtl/sector_fill_ctrl_chk.sv
module sector_fill_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wa_en,
  input logic       cpu_ready,
  input logic       cpu_done,
  input logic       mem_req,
  input logic       mem_we,
  input logic       mem_burst,
  input logic [4:0] mem_lo,
  input logic       mem_ack,
  input logic       mem_rvalid
);
  logic [2:0] beats;

  always_ff @(posedge clk) begin
    if (!rst_n) beats <= '0;
    else if (mem_req && !mem_we && mem_ack) beats <= '0;
    else if (mem_rvalid) beats <= beats + 3'd1;
  end

  assert_idle_no_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> $past(!cpu_ready));
  assert_fill_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_burst && mem_lo == 5'd0));
  assert_four_beats_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> (beats < 3'd4 && !mem_req));
  assert_fill_after_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (beats == 3'd0 || beats == 3'd4));
  assert_no_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_burst) |-> !wa_en);
  assert_wb_word_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_burst) |-> (mem_lo[2:0] == 3'd0));
endmodule

bind sector_fill_ctrl sector_fill_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wa_en(wa_en), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst), .mem_lo(mem_addr[4:0]),
  .mem_ack(mem_ack), .mem_rvalid(mem_rvalid)
);

// File: tb/sector_fill_ctrl_test.sv
module sector_fill_ctrl_test;
  localparam int AW = 32;
  localparam int NS = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, wa_en, cpu_req, cpu_we, cpu_ready, cpu_done;
  logic [AW-1:0] cpu_addr, mem_addr;
  logic [7:0] cpu_be, mem_be;
  logic [63:0] cpu_wdata, cpu_rdata, mem_wdata, mem_rdata;
  logic mem_req, mem_we, mem_burst, mem_ack, mem_rvalid;

  sector_fill_ctrl #(.ADDR_W(AW), .SETS(NS)) uut (
    .clk(clk), .rst_n(rst_n), .wa_en(wa_en), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_burst(mem_burst), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  logic [63:0] mem    [4096];
  logic [63:0] shadow [4096];
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_rd = 0, n_sw = 0, n_wb = 0, pend = 0, bidx = 0, last_beat = 0, slow = 0;
  int rbase = 0;
  bit gap_en = 0, gap_ph = 0;
  int n_chk = 0, n_fail = 0;

  always @(negedge clk) begin
    mem_ack = 1'b0;
    mem_rvalid = 1'b0;
    if (pend > 0) begin
      gap_ph = ~gap_ph;
      if (!gap_en || gap_ph) begin
        mem_rvalid = 1'b1;
        mem_rdata = mem[rbase + bidx];
        bidx++;
        pend--;
        last_beat = cyc;
      end
    end else if (mem_req) begin
      slow++;
      if (!gap_en || (slow % 3) != 0) begin
        mem_ack = 1'b1;
        if (!mem_we) begin
          n_rd++;
          rbase = int'(mem_addr[14:3]);
          bidx = 0;
          pend = 4;
        end else begin
          for (int b = 0; b < 8; b++)
            if (mem_be[b]) mem[mem_addr[14:3]][8*b +: 8] = mem_wdata[8*b +: 8];
          if (mem_burst) n_wb++; else n_sw++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] A(int t, int s, int l, int w);
    return 32'(t*256 + s*64 + l*32 + w*8);
  endfunction

  logic [63:0] rd_v;
  int done_cyc, b_rd, b_sw, b_wb;
  bit busy_ok;

  task automatic op(input bit we, input logic [31:0] a, input logic [7:0] be, input logic [63:0] d);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    b_rd = n_rd; b_sw = n_sw; b_wb = n_wb;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    busy_ok = !cpu_ready;
    while (!cpu_done) @(negedge clk);
    done_cyc = cyc;
    rd_v = cpu_rdata;
    if (we)
      for (int b = 0; b < 8; b++)
        if (be[b]) shadow[a[14:3]][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic rdchk(input logic [31:0] a, input string rq);
    op(1'b0, a, 8'h00, 64'h0);
    check(rd_v == shadow[a[14:3]], rq, rd_v, shadow[a[14:3]]);
  endtask

  task automatic traffic(input int r, input int w1, input int wb, input string rq);
    check(n_rd - b_rd == r, {rq, " burst reads"}, 64'(n_rd - b_rd), 64'(r));
    check(n_sw - b_sw == w1, {rq, " single writes"}, 64'(n_sw - b_sw), 64'(w1));
    check(n_wb - b_wb == wb, {rq, " write-back beats"}, 64'(n_wb - b_wb), 64'(wb));
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] x;
    for (int i = 0; i < 4096; i++) begin
      mem[i] = {32'(i * 32'h9E3779B1), 32'(i) ^ 32'h5A5A0000};
      shadow[i] = mem[i];
    end
    rst_n = 1'b0; wa_en = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0;
    cpu_addr = '0; cpu_be = '0; cpu_wdata = '0;
    mem_ack = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_ready == 1'b1, "R11 ready after reset", 64'(cpu_ready), 64'd1);
    check(mem_req == 1'b0, "R11 mem_req after reset", 64'(mem_req), 64'd0);
    check(cpu_done == 1'b0, "R11 done after reset", 64'(cpu_done), 64'd0);

    rdchk(A(0,0,0,0), "R2 cold read data");
    traffic(1, 0, 0, "R11 cold miss");
    check(busy_ok, "R10 ready low after accept", 64'(busy_ok), 64'd1);
    check(done_cyc == last_beat + 2, "R5 read done after last beat", 64'(done_cyc), 64'(last_beat + 2));
    @(negedge clk);
    check(cpu_done == 1'b0, "R10 done one cycle", 64'(cpu_done), 64'd0);
    for (int w = 1; w < 4; w++) begin
      rdchk(A(0,0,0,w), "R1 hit data");
      traffic(0, 0, 0, "R1 hit");
    end
    rdchk(A(0,0,1,2), "R3 line fill data");
    traffic(1, 0, 0, "R3 line fill");
    rdchk(A(0,0,0,0), "R3 sibling kept data");
    traffic(0, 0, 0, "R3 sibling kept");

    rdchk(A(1,0,0,0), "R4 second way data");
    traffic(1, 0, 0, "R4 second way");
    rdchk(A(0,0,1,0), "R4 first way kept");
    traffic(0, 0, 0, "R4 first way kept");
    for (int k = 0; k < 3; k++) rdchk(A(0,0,0,k), "R4 hits on way0");
    rdchk(A(2,0,0,0), "R4 replace data");
    traffic(1, 0, 0, "R4 replace");
    rdchk(A(1,0,0,3), "R4 hits left order");
    traffic(0, 0, 0, "R4 hits left order");
    rdchk(A(0,0,0,0), "R4 oldest evicted data");
    traffic(1, 0, 0, "R4 oldest evicted");
    rdchk(A(2,0,1,0), "R2 sibling invalid data");
    traffic(1, 0, 0, "R2 sibling invalid");

    op(1'b1, A(3,1,0,2), 8'h0F, 64'h1122334455667788);
    traffic(1, 0, 0, "R6 write allocate");
    check(done_cyc == last_beat + 2, "R6 done after merge", 64'(done_cyc), 64'(last_beat + 2));
    rdchk(A(3,1,0,2), "R6 merged word");
    traffic(0, 0, 0, "R6 line allocated");
    rdchk(A(3,1,0,1), "R6 filled word");

    op(1'b1, A(3,1,0,2), 8'hF0, 64'hCAFEF00D00000000);
    traffic(0, 0, 0, "R8 write hit");
    rdchk(A(3,1,0,2), "R8 write hit data");

    rdchk(A(4,1,0,0), "R9 clean victim");
    traffic(1, 0, 0, "R9 clean victim");
    rdchk(A(5,1,0,0), "R9 dirty victim data");
    traffic(1, 0, 4, "R9 dirty victim");
    check(mem[A(3,1,0,2) >> 3] == shadow[A(3,1,0,2) >> 3], "R9 memory updated",
          mem[A(3,1,0,2) >> 3], shadow[A(3,1,0,2) >> 3]);
    rdchk(A(3,1,0,2), "R9 reread data");

    wa_en = 1'b0;
    op(1'b1, A(6,2,0,0), 8'h3C, 64'hA1B2C3D4E5F60718);
    traffic(0, 1, 0, "R7 no allocate write");
    check(mem[A(6,2,0,0) >> 3] == shadow[A(6,2,0,0) >> 3], "R7 memory word",
          mem[A(6,2,0,0) >> 3], shadow[A(6,2,0,0) >> 3]);
    rdchk(A(6,2,0,0), "R7 reread data");
    traffic(1, 0, 0, "R7 not allocated");

    x = 32'h1234567;
    gap_en = 1'b1;
    for (int n = 0; n < 800; n++) begin
      logic [31:0] a;
      x = x * 32'd1103515245 + 32'd12345;
      a = A(int'((x >> 20) % 6), int'((x >> 16) & 3), int'((x >> 15) & 1), int'((x >> 13) & 3));
      if (n % 200 == 0) wa_en = ~wa_en;
      if (x[31]) op(1'b1, a, x[11:4], {x, ~x});
      else rdchk(a, "R1 sweep read");
    end
    gap_en = 1'b0;
    for (int t = 0; t < 6; t++)
      for (int s = 0; s < 4; s++)
        for (int l = 0; l < 2; l++)
          for (int w = 0; w < 4; w++)
            rdchk(A(t,s,l,w), "R9 final sweep");
    finish_run();
  end
endmodule